// File: doc/BRIEF.md
# Six-Channel RGB PWM Blink Engine

This block produces the switch-enable levels for six LED sinks, organised as two red/green/blue groups. Each output takes a 4-bit brightness code and a 4-bit ramp rate. It also takes 4-bit turn-on and turn-off points inside a repeating blink period, and one enable bit. All timing is counted in a 1 µs strobe that arrives from outside the block.

There are two PWM modes. In the normal mode, the three colours of a group take turns in fixed 50 µs slots of a 150 µs frame, so no two colours of a group conduct at once. In the flash mode, the three colours of a group all pulse together in a 50 µs frame. A shared 2-bit select sets the blink period. Each output has its own on and off points within that period, and its brightness ramps linearly up and down at its own rate.

A master start gates the whole function and restarts all timing when it is raised. A static mode bypasses the PWM so that each output follows its enable bit alone. An external PWM input can gate any chosen subset of the outputs.

Top module: `rgb_blink_engine`

## Requirements
- R1: While start_i is low every bit of out_o is 0 and all timing is held at zero; after start_i rises the PWM frame and the blink period both begin at their first position (slot 0 of the red phase, blink position 0).
- R2: In normal mode, channels 0 and 3 (red) drive in phase 0, channels 1 and 4 (green) in phase 1 and channels 2 and 5 (blue) in phase 2. Each phase lasts PHASE_US ticks, and the phases repeat in the order 0, 1, 2. At most one output of a group is high at any time.
- R3: Within its active phase an output is high at slot u (0 to PHASE_US-1) exactly when 15*u < d*PHASE_US, where d is its effective duty code. Code 0 never lights the output and code 15 lights the whole phase.
- R4: When flash_i[g] is set, the three outputs of group g (channels 3g to 3g+2) use the R3 compare in every PHASE_US frame at the same time, with no phasing.
- R5: The blink period is BLINK_BASE_US << cycle_sel_i ticks (codes 00, 01, 10, 11 give 1x, 2x, 4x, 8x). It is split into 16 equal positions, counted 0 to 15.
- R6: With on point a and off point b (a != b), the ramp target is the duty code at positions p where a <= p < b, or where p >= a or p < b if a > b. At every other position the target is 0.
- R7: With on point 0 and off point 0 the output runs steadily at its duty code at once, with no blinking and no ramp.
- R8: With on point equal to off point and not 0 the output stays low.
- R9: Outside R7 and R8 the effective duty moves one code toward the target every (slope+1)*RAMP_STEP_US ticks, for slope code 0 to 15, and it starts from 0 when start_i rises.
- R10: With pwm_en_i low each output equals its enable bit (still gated by R1, R11 and R12).
- R11: An output whose en_i bit is 0 is always low, in every mode.
- R12: An output whose ext_sel_i bit is 1 is forced low while ext_pwm_i is 0 and is unaffected while ext_pwm_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 1 µs timing strobe |
| start_i | input | 1 | Master start |
| pwm_en_i | input | 1 | Internal PWM and blink enable |
| cycle_sel_i | input | 2 | Blink period select |
| flash_i | input | NUM_GRP | Flash mode per group |
| en_i | input | NUM_CH | Output enables |
| ext_sel_i | input | NUM_CH | External PWM gating select |
| ext_pwm_i | input | 1 | External PWM input |
| duty_i | input | 4*NUM_CH | Duty codes, channel n in bits 4n+3:4n |
| slope_i | input | 4*NUM_CH | Ramp rate codes, same packing |
| on_pt_i | input | 4*NUM_CH | Blink on points, same packing |
| off_pt_i | input | 4*NUM_CH | Blink off points, same packing |
| out_o | output | NUM_CH | Switch enables, active high |

## Verification
A table of duty codes is applied on several channels in both normal and flash mode. The on-cycles are counted over a whole normal frame, which separates the per-phase compare from the simultaneous flash timing and shows up any wrong code-to-time scaling. With all six channels at full duty, the bench looks for overlap and phase order inside each group. Blink windows are run at two cycle selects, so that a wrong period or position decode moves the lit interval. Two slope codes are compared by the time to first light and by the duty level reached later in the window. Further patterns cover the steady and held-off on/off pairs, the static mode, the enable bits and the external gating.

// File: rtl/rgb_blink_pkg.sv
package rgb_blink_pkg;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned NUM_PHASE = 3;
  localparam int unsigned CODE_MAX  = 15;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/rgb_frame_timer.sv
module rgb_frame_timer #(
  parameter int unsigned PHASE_US = 50,
  localparam int unsigned SLOT_W  = $clog2(PHASE_US)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [1:0]        phase_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_o  <= '0;
      phase_o <= '0;
    end else if (!run_i) begin
      slot_o  <= '0;
      phase_o <= '0;
    end else if (tick_i) begin
      if (slot_o == SLOT_W'(PHASE_US - 1)) begin
        slot_o  <= '0;
        phase_o <= (phase_o == 2'd2) ? 2'd0 : phase_o + 2'd1;
      end else begin
        slot_o <= slot_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rgb_blink_timer.sv
module rgb_blink_timer #(
  parameter int unsigned BLINK_BASE_US = 250000,
  localparam int unsigned SUB_BASE = BLINK_BASE_US / 16,
  localparam int unsigned SUB_W    = $clog2(SUB_BASE * 8 + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic       tick_i,
  input  logic [1:0] cycle_sel_i,
  output logic [3:0] pos_o
);
  logic [SUB_W-1:0] sub_q, sub_lim;

  // one sixteenth of the selected period, minus one
  always_comb sub_lim = (SUB_W'(SUB_BASE) << cycle_sel_i) - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
      pos_o <= '0;
    end else if (!run_i) begin
      sub_q <= '0;
      pos_o <= '0;
    end else if (tick_i) begin
      if (sub_q >= sub_lim) begin
        sub_q <= '0;
        pos_o <= pos_o + 4'd1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rgb_pwm_channel.sv
module rgb_pwm_channel
  import rgb_blink_pkg::*;
#(
  parameter int unsigned PHASE_US     = 50,
  parameter int unsigned RAMP_STEP_US = 2000,
  parameter int unsigned MY_PHASE     = 0,
  localparam int unsigned SLOT_W = $clog2(PHASE_US),
  localparam int unsigned RAMP_W = $clog2(RAMP_STEP_US * 16 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  code_t             duty_i,
  input  code_t             slope_i,
  input  code_t             on_pt_i,
  input  code_t             off_pt_i,
  input  logic [3:0]        pos_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [1:0]        phase_i,
  input  logic              flash_i,
  output logic              lit_o
);
  code_t             cur_q, target, eff;
  logic [RAMP_W-1:0] cnt_q, step_lim;
  logic              steady, dark, in_win, my_turn;

  always_comb begin
    steady   = (on_pt_i == '0) && (off_pt_i == '0);
    dark     = (on_pt_i == off_pt_i) && !steady;
    if (on_pt_i < off_pt_i) in_win = (pos_i >= on_pt_i) && (pos_i < off_pt_i);
    else                    in_win = (pos_i >= on_pt_i) || (pos_i < off_pt_i);
    target   = in_win ? duty_i : '0;
    step_lim = RAMP_W'((32'(slope_i) + 32'd1) * RAMP_STEP_US - 32'd1);
    eff      = steady ? duty_i : (dark ? '0 : cur_q);
    my_turn  = flash_i || (32'(phase_i) == MY_PHASE);
    lit_o    = run_i && my_turn && (eff != '0) &&
               ((32'(slot_i) * CODE_MAX) < (32'(eff) * PHASE_US));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else if (!run_i || dark) begin
      cur_q <= '0;
      cnt_q <= '0;
    end else if (steady) begin
      cur_q <= duty_i;
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cur_q == target) begin
        cnt_q <= '0;
      end else if (cnt_q >= step_lim) begin
        cnt_q <= '0;
        cur_q <= (cur_q < target) ? cur_q + 4'd1 : cur_q - 4'd1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rgb_blink_engine.sv
module rgb_blink_engine
  import rgb_blink_pkg::*;
#(
  parameter int unsigned NUM_GRP       = 2,
  parameter int unsigned PHASE_US      = 50,
  parameter int unsigned BLINK_BASE_US = 250000,
  parameter int unsigned RAMP_STEP_US  = 2000,
  localparam int unsigned NUM_CH = NUM_GRP * NUM_PHASE,
  localparam int unsigned SLOT_W = $clog2(PHASE_US)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic                     start_i,
  input  logic                     pwm_en_i,
  input  logic [1:0]               cycle_sel_i,
  input  logic [NUM_GRP-1:0]       flash_i,
  input  logic [NUM_CH-1:0]        en_i,
  input  logic [NUM_CH-1:0]        ext_sel_i,
  input  logic                     ext_pwm_i,
  input  logic [CODE_W*NUM_CH-1:0] duty_i,
  input  logic [CODE_W*NUM_CH-1:0] slope_i,
  input  logic [CODE_W*NUM_CH-1:0] on_pt_i,
  input  logic [CODE_W*NUM_CH-1:0] off_pt_i,
  output logic [NUM_CH-1:0]        out_o
);
  logic [SLOT_W-1:0] slot;
  logic [1:0]        phase;
  logic [3:0]        pos;
  logic [NUM_CH-1:0] lit;

  rgb_frame_timer #(.PHASE_US(PHASE_US)) u_frame (
    .clk_i, .rst_ni, .run_i(start_i), .tick_i,
    .slot_o(slot), .phase_o(phase)
  );

  rgb_blink_timer #(.BLINK_BASE_US(BLINK_BASE_US)) u_blink (
    .clk_i, .rst_ni, .run_i(start_i), .tick_i, .cycle_sel_i,
    .pos_o(pos)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rgb_pwm_channel #(
      .PHASE_US(PHASE_US), .RAMP_STEP_US(RAMP_STEP_US),
      .MY_PHASE(c % NUM_PHASE)
    ) u_ch (
      .clk_i, .rst_ni, .run_i(start_i), .tick_i,
      .duty_i  (duty_i  [c*CODE_W +: CODE_W]),
      .slope_i (slope_i [c*CODE_W +: CODE_W]),
      .on_pt_i (on_pt_i [c*CODE_W +: CODE_W]),
      .off_pt_i(off_pt_i[c*CODE_W +: CODE_W]),
      .pos_i(pos), .slot_i(slot), .phase_i(phase),
      .flash_i(flash_i[c / NUM_PHASE]),
      .lit_o(lit[c])
    );

    always_comb
      out_o[c] = start_i && en_i[c] && (!pwm_en_i || lit[c]) &&
                 (!ext_sel_i[c] || ext_pwm_i);
  end
endmodule

// File: rtl/rgb_blink_engine_chk.sv
module rgb_blink_engine_chk #(
  parameter int unsigned NUM_GRP = 2,
  localparam int unsigned NUM_CH = NUM_GRP * 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              pwm_en_i,
  input logic [NUM_GRP-1:0] flash_i,
  input logic [NUM_CH-1:0] en_i,
  input logic [NUM_CH-1:0] ext_sel_i,
  input logic              ext_pwm_i,
  input logic [NUM_CH-1:0] out_o
);
  a_r1_stopped_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |-> out_o == '0);

  a_r11_disabled_dark: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_o & ~en_i) == '0);

  a_r12_ext_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_pwm_i |-> (out_o & ext_sel_i) == '0);

  a_r10_static_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !pwm_en_i && ext_sel_i == '0) |-> out_o == en_i);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    a_r2_one_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pwm_en_i && !flash_i[g]) |-> $onehot0(out_o[3*g +: 3]));
  end
endmodule

bind rgb_blink_engine rgb_blink_engine_chk #(.NUM_GRP(NUM_GRP)) u_chk (.*);

// File: tb/rgb_blink_engine_test.sv
module rgb_blink_engine_test;
  localparam int NG = 2, NC = 6, PH = 5, BASE = 160, STEP = 4;

  logic clk_i = 0, rst_ni = 0, tick_i = 1, start_i = 0, pwm_en_i = 1, ext_pwm_i = 0;
  logic [1:0] cycle_sel_i = 0;
  logic [NG-1:0] flash_i = 0;
  logic [NC-1:0] en_i = '1, ext_sel_i = 0, out_o;
  logic [4*NC-1:0] duty_i = 0, slope_i = 0, on_pt_i = 0, off_pt_i = 0;

  int checks = 0, errors = 0, c, c2;

  rgb_blink_engine #(.NUM_GRP(NG), .PHASE_US(PH), .BLINK_BASE_US(BASE),
                     .RAMP_STEP_US(STEP)) uut (.*);

  always #10 clk_i = ~clk_i;

  // channel, duty, flash, expected on-count over 15 ticks
  localparam int VEC[8][4] = '{
    '{0, 0, 0, 0}, '{0, 15, 0, 5}, '{0, 7, 0, 3}, '{1, 1, 0, 1},
    '{2, 15, 1, 15}, '{4, 9, 1, 9}, '{5, 4, 0, 2}, '{3, 13, 1, 15}};

  task automatic check(input int got, input int exp, input string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin @(negedge clk_i); #1; end
  endtask

  task automatic count(input int ch, input int n, output int r);
    r = 0;
    repeat (n) begin
      if (out_o[ch]) r++;
      @(negedge clk_i); #1;
    end
  endtask

  task automatic restart();
    @(negedge clk_i); start_i = 0;
    @(negedge clk_i); start_i = 1; #1;
  endtask

  task automatic set_ch(input int ch, input int d, input int s, input int a, input int b);
    duty_i[4*ch +: 4] = 4'(d); slope_i[4*ch +: 4] = 4'(s);
    on_pt_i[4*ch +: 4] = 4'(a); off_pt_i[4*ch +: 4] = 4'(b);
  endtask

  task automatic clear_cfg();
    duty_i = 0; slope_i = 0; on_pt_i = 0; off_pt_i = 0; flash_i = 0;
    en_i = '1; ext_sel_i = 0; pwm_en_i = 1; cycle_sel_i = 0; ext_pwm_i = 0;
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(3); rst_ni = 1; step(2);
    check(int'(out_o), 0, "R1 reset state");

    // R3 R4 duty table
    for (int i = 0; i < 8; i++) begin
      clear_cfg();
      set_ch(VEC[i][0], VEC[i][1], 0, 0, 0);
      flash_i[VEC[i][0] / 3] = VEC[i][2][0];
      restart();
      count(VEC[i][0], 15, c);
      check(c, VEC[i][3], $sformatf("R3/R4 vec %0d", i));
    end

    // R2 phase order and exclusivity, R1 restart at red phase
    clear_cfg();
    for (int ch = 0; ch < NC; ch++) set_ch(ch, 15, 0, 0, 0);
    restart();
    check(int'(out_o), 6'b001_001, "R1 R2 first slot red only");
    step(PH);
    check(int'(out_o), 6'b010_010, "R2 second phase green");
    c2 = 0;
    for (int t = 0; t < 30; t++) begin
      if ($countones(out_o[2:0]) > 1 || $countones(out_o[5:3]) > 1) c2++;
      step(1);
    end
    check(c2, 0, "R2 no overlap");
    start_i = 0; #1;
    check(int'(out_o), 0, "R1 stop clears outputs");

    // R6 R9 blink window with ramp, normal mode
    clear_cfg(); set_ch(0, 3, 0, 4, 8);
    restart();
    step(5);  count(0, 30, c); check(c, 0, "R6 before on point");
    step(25); count(0, 15, c); check(c, 1, "R6 inside window");
    step(25); count(0, 55, c); check(c, 0, "R6 after off point");

    // R9 ramp rate, flash full duty
    clear_cfg(); flash_i = 2'b01; set_ch(0, 15, 3, 0, 8);
    restart();
    count(0, 16, c); check(c, 0, "R9 slope3 dark before first step");
    count(0, 5, c);  check(c, 1, "R9 slope3 first step lit");
    step(44); count(0, 15, c); check(int'(c < 15), 1, "R9 slope3 still ramping");
    clear_cfg(); flash_i = 2'b01; set_ch(0, 15, 0, 0, 8);
    restart();
    count(0, 4, c); check(c, 0, "R9 slope0 dark first 4");
    step(61); count(0, 15, c); check(c, 15, "R9 slope0 full duty reached");

    // R5 cycle select 01 doubles the period
    clear_cfg(); cycle_sel_i = 2'b01; flash_i = 2'b01; set_ch(0, 15, 0, 4, 8);
    restart();
    step(40); count(0, 38, c); check(c, 0, "R5 sel1 before on point");
    step(67); count(0, 13, c); check(c, 13, "R5 sel1 full in window");

    // R7 steady, immediate despite slow slope
    clear_cfg(); set_ch(0, 15, 15, 0, 0);
    restart(); count(0, 15, c); check(c, 5, "R7 steady no ramp");

    // R8 held off
    clear_cfg(); flash_i = 2'b01; set_ch(0, 15, 0, 5, 5);
    restart(); count(0, 160, c); check(c, 0, "R8 equal points dark");

    // R11 enable gating in pwm mode
    clear_cfg(); flash_i = 2'b01; set_ch(0, 15, 0, 0, 0); set_ch(1, 15, 0, 0, 0);
    en_i = 6'b111110;
    restart(); count(0, 15, c); check(c, 0, "R11 disabled channel");
    count(1, 15, c); check(c, 15, "R11 enabled channel");

    // R10 static and R12 external gating
    clear_cfg(); pwm_en_i = 0; en_i = 6'b101001;
    restart(); check(int'(out_o), 6'b101001, "R10 static follows enables");
    ext_sel_i = 6'b000001; #1;
    check(int'(out_o), 6'b101000, "R12 ext low gates selected");
    ext_pwm_i = 1; #1;
    check(int'(out_o), 6'b101001, "R12 ext high passes");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule